// File: doc/BRIEF.md
# Five-Stage Pipeline Stall Controller

This block decides, every cycle, whether an in-order five-stage pipeline (fetch, decode, execute, memory, write-back) may advance. It looks at a few decoded fields from the instruction in decode, from the instruction in execute and from the instruction in the memory stage. From these it drives four controls: a program-counter write enable, a write enable for the fetch/decode register, a request to turn the decode/execute slot into a bubble, and a request to load the fetch/decode register with an empty slot instead of the fetched word.

It handles three hazards. The first is a load whose result is needed at once by the next instruction, which costs one cycle. The second is the single-port memory shared by fetch and data accesses: while a load or store is in the memory stage, fetch is blocked. The third is a control transfer (branch or jump) whose target is only known in the memory stage: once it leaves decode, fetch is held for a fixed number of cycles. The slot fetched while the transfer sits in decode is executed as a delay slot. A bubble means that the datapath clears the valid bit and every write enable of the decode/execute register. Forwarding, the datapath itself and prediction are outside this block.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: While `rst` is high, `pc_write_en`=1, `ifid_write_en`=1, `idex_bubble`=0 and `fetch_squash`=0 regardless of the other inputs, and the control-transfer hold window is cleared, so the first cycle after reset shows no hold.
- R2: A load-use hazard exists when `id_valid`, `ex_valid`, `ex_load` and `ex_wr_en` are all 1, `ex_rd` is nonzero, and it equals `id_rs1` with `id_use_rs1`=1 or `id_rs2` with `id_use_rs2`=1. In that same cycle `pc_write_en`=0, `ifid_write_en`=0, `idex_bubble`=1 and `fetch_squash`=0.
- R3: No load-use hazard is raised, so `idex_bubble`=0, when `ex_rd` is 0, when `ex_wr_en`=0, when `ex_load`=0, when `id_valid`=0, or when the only matching source has its use flag at 0.
- R4: When `mem_valid`=1 and either `mem_load` or `mem_store` is 1, and no load-use hazard exists, `pc_write_en`=0, `ifid_write_en`=1, `fetch_squash`=1 and `idex_bubble`=0 in that cycle.
- R5: A control transfer (`id_valid`=1 and `id_ctl_xfer`=1, with no load-use hazard) leaves the outputs of its own cycle unchanged. For each of the next BR_PENALTY cycles (default 3), fetch is held: `pc_write_en`=0 and `fetch_squash`=1, unless a load-use hazard wins in that cycle. After those cycles the hold ends.
- R6: A control transfer held in decode by a load-use hazard does not start the hold window. The window starts in the cycle in which it leaves decode.
- R7: The hold window keeps counting down in cycles where a load-use or memory-port stall is also active, so overlapping stalls are not added together.
- R8: With no hazard and no hold active, `pc_write_en`=1, `ifid_write_en`=1, `idex_bubble`=0 and `fetch_squash`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | First source is actually read |
| id_use_rs2 | input | 1 | Second source is actually read |
| id_ctl_xfer | input | 1 | Decode instruction is a branch or jump |
| ex_valid | input | 1 | Execute slot holds a real instruction |
| ex_load | input | 1 | Execute instruction is a load |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| mem_valid | input | 1 | Memory slot holds a real instruction |
| mem_load | input | 1 | Memory instruction is a load |
| mem_store | input | 1 | Memory instruction is a store |
| pc_write_en | output | 1 | Program counter may update |
| ifid_write_en | output | 1 | Fetch/decode register may update |
| idex_bubble | output | 1 | Load an empty slot into decode/execute |
| fetch_squash | output | 1 | Load an empty slot into fetch/decode |

## Verification
The interesting collisions are between the control-transfer hold window and the other two stalls. A load-use hazard or a memory-port access is placed inside an open window. The bench then checks that the hazard decides the outputs in its own cycle, and that the window still ends exactly BR_PENALTY cycles after the transfer left decode. The reverse case is a transfer in decode that is blocked by a load-use hazard in the same cycle. There the bench checks that no window is opened until the transfer is driven again free of the hazard.

// File: rtl/pipe_stall_pkg.sv
package pipe_stall_pkg;

  // One source operand matches a live destination (zero never matches).
  function automatic logic src_hit(input logic [31:0] rs, input logic used,
                                   input logic [31:0] rd);
    return used && (rd != 32'd0) && (rs == rd);
  endfunction

  // The single memory port is taken by a data access.
  function automatic logic data_access(input logic vld, input logic ld,
                                       input logic st);
    return vld && (ld || st);
  endfunction

endpackage

// File: rtl/ld_use_unit.sv
module ld_use_unit #(
  parameter int REG_W = 5
) (
  input  logic             id_valid,
  input  logic [1:0][REG_W-1:0] id_src,
  input  logic [1:0]       id_use,
  input  logic             ex_valid,
  input  logic             ex_load,
  input  logic             ex_wr_en,
  input  logic [REG_W-1:0] ex_rd,
  output logic             hit
);
  import pipe_stall_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0] src_m;
  logic            producer;

  assign producer = ex_valid && ex_load && ex_wr_en;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_m[g] = src_hit(32'(id_src[g]), id_use[g], 32'(ex_rd));
  end

  assign hit = id_valid && producer && (|src_m);
endmodule

// File: rtl/port_arb_unit.sv
module port_arb_unit (
  input  logic mem_valid,
  input  logic mem_load,
  input  logic mem_store,
  output logic busy
);
  import pipe_stall_pkg::*;

  assign busy = data_access(mem_valid, mem_load, mem_store);
endmodule

// File: rtl/xfer_hold_unit.sv
module xfer_hold_unit #(
  parameter int BR_PENALTY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic hold
);
  localparam int CW = $clog2(BR_PENALTY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CW'(BR_PENALTY);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign hold = (cnt_q != '0) && !rst;
endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl #(
  parameter int REG_W      = 5,
  parameter int BR_PENALTY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic             id_ctl_xfer,
  input  logic             ex_valid,
  input  logic             ex_load,
  input  logic             ex_wr_en,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_valid,
  input  logic             mem_load,
  input  logic             mem_store,
  output logic             pc_write_en,
  output logic             ifid_write_en,
  output logic             idex_bubble,
  output logic             fetch_squash
);
  // Named internal events, visible to the bound checker.
  logic lu_raw, port_raw;
  logic lu_hit;      // load-use hazard this cycle
  logic port_busy;   // data access holds the memory port
  logic br_start;    // control transfer leaves decode
  logic br_hold;     // fetch held for transfer resolution

  ld_use_unit #(.REG_W(REG_W)) u_lu (
    .id_valid (id_valid),
    .id_src   ({id_rs2, id_rs1}),
    .id_use   ({id_use_rs2, id_use_rs1}),
    .ex_valid (ex_valid),
    .ex_load  (ex_load),
    .ex_wr_en (ex_wr_en),
    .ex_rd    (ex_rd),
    .hit      (lu_raw)
  );

  port_arb_unit u_port (
    .mem_valid (mem_valid),
    .mem_load  (mem_load),
    .mem_store (mem_store),
    .busy      (port_raw)
  );

  assign lu_hit    = lu_raw && !rst;
  assign port_busy = port_raw && !rst;
  assign br_start  = id_valid && id_ctl_xfer && !lu_hit && !rst;

  xfer_hold_unit #(.BR_PENALTY(BR_PENALTY)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .start (br_start),
    .hold  (br_hold)
  );

  // Hazards are OR-combined; a load-use freeze outranks a fetch squash.
  assign pc_write_en   = !(lu_hit || port_busy || br_hold);
  assign ifid_write_en = !lu_hit;
  assign idex_bubble   = lu_hit;
  assign fetch_squash  = (port_busy || br_hold) && !lu_hit;
endmodule

// File: rtl/pipe_stall_chk.sv
module pipe_stall_chk #(
  parameter int REG_W      = 5,
  parameter int BR_PENALTY = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             id_valid,
  input logic             id_ctl_xfer,
  input logic             ex_wr_en,
  input logic [REG_W-1:0] ex_rd,
  input logic             lu_hit,
  input logic             port_busy,
  input logic             br_start,
  input logic             br_hold,
  input logic             pc_write_en,
  input logic             ifid_write_en,
  input logic             idex_bubble,
  input logic             fetch_squash
);
  localparam int CW = $clog2(BR_PENALTY + 1);

  // Independent window tracker: cycles left after a transfer left decode.
  logic [CW-1:0] win_left;
  always_ff @(posedge clk) begin
    if (rst)
      win_left <= '0;
    else if (br_start)
      win_left <= CW'(BR_PENALTY);
    else if (win_left != '0)
      win_left <= win_left - CW'(1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |-> (pc_write_en && ifid_write_en && !idex_bubble && !fetch_squash));

  assert_lu_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    lu_hit |-> (!pc_write_en && !ifid_write_en && idex_bubble && !fetch_squash));

  assert_no_dest_R3: assert property (@(posedge clk) disable iff (rst)
    ((ex_rd == '0) || !ex_wr_en || !id_valid) |-> !idex_bubble);

  assert_port_block_R4: assert property (@(posedge clk) disable iff (rst)
    (port_busy && !lu_hit) |-> (fetch_squash && !pc_write_en && ifid_write_en));

  assert_window_open_R5: assert property (@(posedge clk) disable iff (rst)
    br_start |=> br_hold);

  assert_blocked_xfer_R6: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_ctl_xfer && lu_hit) |-> !br_start);

  assert_window_len_R7: assert property (@(posedge clk) disable iff (rst)
    br_hold == (win_left != '0));

  assert_free_flow_R8: assert property (@(posedge clk) disable iff (rst)
    (!lu_hit && !port_busy && !br_hold) |->
      (pc_write_en && ifid_write_en && !idex_bubble && !fetch_squash));
endmodule

bind pipe_stall_ctrl pipe_stall_chk #(.REG_W(REG_W), .BR_PENALTY(BR_PENALTY)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .id_valid      (id_valid),
  .id_ctl_xfer   (id_ctl_xfer),
  .ex_wr_en      (ex_wr_en),
  .ex_rd         (ex_rd),
  .lu_hit        (lu_hit),
  .port_busy     (port_busy),
  .br_start      (br_start),
  .br_hold       (br_hold),
  .pc_write_en   (pc_write_en),
  .ifid_write_en (ifid_write_en),
  .idex_bubble   (idex_bubble),
  .fetch_squash  (fetch_squash)
);

// File: tb/pipe_stall_ctrl_tb.sv
module pipe_stall_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 5;

  typedef struct packed {
    logic       iv;
    logic [4:0] r1;
    logic [4:0] r2;
    logic       u1;
    logic       u2;
    logic       br;
    logic       ev;
    logic       el;
    logic       ew;
    logic [4:0] rd;
    logic       mv;
    logic       ml;
    logic       ms;
    logic [3:0] exp;   // {pc_write_en, ifid_write_en, idex_bubble, fetch_squash}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  // Vectors are applied on consecutive cycles; the hold window carries over.
  localparam vec_t VEC [NV] = '{
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b1100, 4'd8}, // R8 idle
    '{1'b1,5'd3,5'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,5'd3, 1'b0,1'b0,1'b0, 4'b0010, 4'd2}, // R2 rs1
    '{1'b1,5'd7,5'd3,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1,5'd3, 1'b0,1'b0,1'b0, 4'b0010, 4'd2}, // R2 rs2
    '{1'b1,5'd0,5'd0,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1,5'd0, 1'b0,1'b0,1'b0, 4'b1100, 4'd3}, // R3 reg zero
    '{1'b1,5'd3,5'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,5'd3, 1'b0,1'b0,1'b0, 4'b1100, 4'd3}, // R3 no write
    '{1'b1,5'd3,5'd0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,5'd3, 1'b0,1'b0,1'b0, 4'b1100, 4'd3}, // R3 not load
    '{1'b1,5'd3,5'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,5'd3, 1'b0,1'b0,1'b0, 4'b1100, 4'd3}, // R3 unused src
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b1,1'b1,1'b0, 4'b0101, 4'd4}, // R4 load in mem
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,1'b1, 4'b0101, 4'd4}, // R4 store in mem
    '{1'b1,5'd9,5'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,5'd9, 1'b1,1'b0,1'b1, 4'b0010, 4'd4}, // R4 with R2 win
    '{1'b1,5'd0,5'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b1100, 4'd5}, // R5 xfer cycle
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b0101, 4'd5}, // R5 hold 1
    '{1'b1,5'd6,5'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,5'd6, 1'b0,1'b0,1'b0, 4'b0010, 4'd7}, // R7 lu in window
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b0101, 4'd7}, // R7 hold 3
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b1100, 4'd7}, // R7 window over
    '{1'b1,5'd4,5'd0,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b1,5'd4, 1'b0,1'b0,1'b0, 4'b0010, 4'd6}, // R6 xfer blocked
    '{1'b1,5'd4,5'd0,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b1100, 4'd6}, // R6 xfer leaves
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b1,1'b1,1'b0, 4'b0101, 4'd7}, // R7 port in window
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b0101, 4'd7}, // R7 hold 2
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b0101, 4'd7}, // R7 hold 3
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b1100, 4'd6}, // R6 window over
    '{1'b0,5'd5,5'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,5'd5, 1'b0,1'b0,1'b0, 4'b1100, 4'd3}, // R3 id invalid
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b1100, 4'd5}, // R5 invalid xfer
    '{1'b0,5'd0,5'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,1'b0, 4'b1100, 4'd5}, // R5 no window
    '{1'b1,5'd5,5'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,5'd5, 1'b0,1'b0,1'b0, 4'b0010, 4'd2}, // R2 back-to-back loads
    '{1'b1,5'd5,5'd0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,5'd0, 1'b1,1'b1,1'b0, 4'b0101, 4'd4}  // R4 first load in mem
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic id_valid, id_use_rs1, id_use_rs2, id_ctl_xfer;
  logic [REG_W-1:0] id_rs1, id_rs2, ex_rd;
  logic ex_valid, ex_load, ex_wr_en, mem_valid, mem_load, mem_store;
  logic pc_write_en, ifid_write_en, idex_bubble, fetch_squash;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pipe_stall_ctrl #(.REG_W(REG_W), .BR_PENALTY(3)) u_dut (
    .clk(clk), .rst(rst),
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .id_ctl_xfer(id_ctl_xfer),
    .ex_valid(ex_valid), .ex_load(ex_load), .ex_wr_en(ex_wr_en), .ex_rd(ex_rd),
    .mem_valid(mem_valid), .mem_load(mem_load), .mem_store(mem_store),
    .pc_write_en(pc_write_en), .ifid_write_en(ifid_write_en),
    .idex_bubble(idex_bubble), .fetch_squash(fetch_squash)
  );

  task automatic drive(input vec_t v);
    id_valid = v.iv; id_rs1 = v.r1; id_rs2 = v.r2;
    id_use_rs1 = v.u1; id_use_rs2 = v.u2; id_ctl_xfer = v.br;
    ex_valid = v.ev; ex_load = v.el; ex_wr_en = v.ew; ex_rd = v.rd;
    mem_valid = v.mv; mem_load = v.ml; mem_store = v.ms;
  endtask

  task automatic check(input logic [3:0] exp, input int req, input string what);
    logic [3:0] act;
    act = {pc_write_en, ifid_write_en, idex_bubble, fetch_squash};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic vec_t mkv(input logic iv, input logic [4:0] r1, input logic br,
                               input logic el, input logic [4:0] rd, input logic ml);
    vec_t v;
    v = '0;
    v.iv = iv; v.r1 = r1; v.u1 = iv; v.br = br;
    v.ev = el; v.el = el; v.ew = el; v.rd = rd;
    v.mv = ml; v.ml = ml;
    return v;
  endfunction

  initial begin
    drive(mkv(1'b1, 5'd2, 1'b0, 1'b1, 5'd2, 1'b1));
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    check(4'b1100, 1, "outputs idle in reset despite hazards"); // R1

    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k]);
      #1;
      check(VEC[k].exp, int'(VEC[k].req), $sformatf("vector %0d", k));
    end

    // R1: reset in the middle of a hold window clears it.
    @(negedge clk); drive(mkv(1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b0)); #1;
    check(4'b1100, 5, "transfer before reset");
    @(negedge clk); drive(mkv(1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0)); #1;
    check(4'b0101, 5, "window open");
    @(negedge clk); rst = 1'b1; #1;
    check(4'b1100, 1, "reset masks window");
    @(negedge clk); rst = 1'b0; #1;
    check(4'b1100, 1, "window cleared by reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule